// File: doc/BRIEF.md
# Coherent Crossbar Snoop Filter

This block sits inside a coherent crossbar and tracks, for a small set of cache lines, which requester ports hold a copy and which ports have a request in flight. Each line has an entry in a direct-mapped table, indexed by the low bits of the line address and tagged with the rest. Every entry carries two per-port vectors: a holder vector and a pending vector.

When a request arrives, the filter looks up its line and updates that line's entry. One cycle later it reports the set of ports the crossbar must snoop, the pending vector after the update, whether the lookup hit, and whether the request still has to go to memory. A shared read snoops every holder except the requester. An upgrade from a port that already holds the line snoops the other holders. A lookup that misses allocates a fresh entry and sends the request straight to memory.

Snoop responses also pass through the filter on their way back to the requester. A response moves the requester from pending to holder and leaves the responding port as a holder. A completed upgrade leaves the requester as the only holder. If no snooped holder supplies the data for a read, the filter reports one cycle later that memory must serve it.

Top module: `snoop_filter`

## Requirements
- R1: After reset every table entry is invalid and all outputs are 0.
- R2: A request presented with `req_valid_i` high produces `lk_valid_o` high exactly one clock later, together with that request's lookup results.
- R3: A lookup that misses (entry invalid, or its tag differs from `req_addr_i[ADDR_W-1:IDX_W]`) replaces the entry at index `req_addr_i[IDX_W-1:0]`. The new entry has an empty holder vector and a pending vector holding only the requester. The result reports `lk_hit_o`=0, `lk_snoop_o`=0, `lk_pend_o` = the requester bit (bit n for port n), and `lk_mem_o`=1.
- R4: A shared read (`req_upg_i`=0) that hits sets the requester's pending bit. It reports as snoop set the holder vector without the requester's bit. `lk_mem_o`=1 only when that snoop set is empty.
- R5: An upgrade (`req_upg_i`=1) that hits sets the requester's pending bit, snoops every holder other than the requester, and reports `lk_mem_o`=0.
- R6: A response (`rsp_valid_i`) for a tracked line clears the pending bit of port `rsp_port_i` and sets its holder bit. The holder bits of all other ports are left unchanged, so the responding holder stays a holder.
- R7: A response with `rsp_upg_i`=1 for a tracked line also clears the holder bits of every port other than `rsp_port_i`.
- R8: A response whose address misses in the table changes no entry.
- R9: `rsp_mem_o` is 1 exactly one clock after a response with `rsp_upg_i`=0 and `rsp_data_i`=0 (no holder supplied the data). Otherwise it is 0.
- R10: When a response and a request reach the same entry in the same cycle, the response is applied first and the request's lookup sees the updated entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_upg_i | input | 1 | 1 = upgrade, 0 = shared read |
| req_port_i | input | PORT_W | Requesting port |
| req_addr_i | input | ADDR_W | Line address of the request |
| rsp_valid_i | input | 1 | Snoop response passing through |
| rsp_upg_i | input | 1 | Response completes an upgrade |
| rsp_data_i | input | 1 | A holder supplied the data |
| rsp_port_i | input | PORT_W | Port that issued the original request |
| rsp_addr_i | input | ADDR_W | Line address of the response |
| lk_valid_o | output | 1 | Lookup result valid |
| lk_hit_o | output | 1 | Lookup found a tracked line |
| lk_snoop_o | output | NUM_PORTS | Ports to snoop |
| lk_pend_o | output | NUM_PORTS | Pending vector after the request |
| lk_mem_o | output | 1 | Request must be sent to memory |
| rsp_mem_o | output | 1 | Read response found no supplier; memory must serve it |

## Verification
A directed sequence first walks one line through its whole life. A cold miss is followed by a read served by memory, then a read served by a holder, then a third reader, an upgrade by a current holder and its completion. This separates the snoop masks for "no holder", "one other holder", "several holders" and "requester is itself a holder". Stray responses to untracked lines and same-index lines with different tags then show whether the tag compare and the replacement behave. A response and a request that meet on one entry in the same cycle show the order in which they are applied. A long random stream over a few aliasing addresses then mixes all of these with a behavioural model compared on every cycle.

// File: rtl/snoop_filter_pkg.sv
package snoop_filter_pkg;
  typedef enum logic {
    REQ_RD_SHARED = 1'b0,
    REQ_UPGRADE   = 1'b1
  } req_kind_e;
endpackage

// File: rtl/sf_req_update.sv
module sf_req_update
  import snoop_filter_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int TAG_W     = 10,
  localparam int PORT_W   = $clog2(NUM_PORTS)
) (
  input  logic                 vld_i,
  input  logic [TAG_W-1:0]     tag_i,
  input  logic [NUM_PORTS-1:0] hold_i,
  input  logic [NUM_PORTS-1:0] pend_i,
  input  logic [TAG_W-1:0]     req_tag_i,
  input  logic [PORT_W-1:0]    req_port_i,
  input  req_kind_e            req_kind_i,
  output logic                 vld_o,
  output logic [TAG_W-1:0]     tag_o,
  output logic [NUM_PORTS-1:0] hold_o,
  output logic [NUM_PORTS-1:0] pend_o,
  output logic                 hit_o,
  output logic [NUM_PORTS-1:0] snoop_o,
  output logic                 mem_o
);
  logic [NUM_PORTS-1:0] self;
  assign self = NUM_PORTS'(1) << req_port_i;

  always_comb begin
    hit_o = vld_i && (tag_i == req_tag_i);
    vld_o = 1'b1;
    tag_o = req_tag_i;
    if (hit_o) begin
      hold_o  = hold_i;
      pend_o  = pend_i | self;
      snoop_o = hold_i & ~self;
      mem_o   = (req_kind_i == REQ_RD_SHARED) && (snoop_o == '0);
    end else begin
      // fresh entry: nobody can supply, memory serves
      hold_o  = '0;
      pend_o  = self;
      snoop_o = '0;
      mem_o   = 1'b1;
    end
  end
endmodule

// File: rtl/sf_rsp_update.sv
module sf_rsp_update #(
  parameter int NUM_PORTS = 4,
  parameter int TAG_W     = 10,
  localparam int PORT_W   = $clog2(NUM_PORTS)
) (
  input  logic                 vld_i,
  input  logic [TAG_W-1:0]     tag_i,
  input  logic [NUM_PORTS-1:0] hold_i,
  input  logic [NUM_PORTS-1:0] pend_i,
  input  logic                 rsp_valid_i,
  input  logic [TAG_W-1:0]     rsp_tag_i,
  input  logic [PORT_W-1:0]    rsp_port_i,
  input  logic                 rsp_upg_i,
  output logic                 vld_o,
  output logic [TAG_W-1:0]     tag_o,
  output logic [NUM_PORTS-1:0] hold_o,
  output logic [NUM_PORTS-1:0] pend_o
);
  logic [NUM_PORTS-1:0] self;
  logic                 hit;
  assign self = NUM_PORTS'(1) << rsp_port_i;
  assign hit  = rsp_valid_i && vld_i && (tag_i == rsp_tag_i);

  always_comb begin
    vld_o  = vld_i;
    tag_o  = tag_i;
    hold_o = hold_i;
    pend_o = pend_i;
    if (hit) begin
      pend_o = pend_i & ~self;
      hold_o = rsp_upg_i ? self : (hold_i | self);
    end
  end
endmodule

// File: rtl/snoop_filter.sv
module snoop_filter
  import snoop_filter_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 12,
  parameter int IDX_W     = 2,
  localparam int PORT_W   = $clog2(NUM_PORTS),
  localparam int TAG_W    = ADDR_W - IDX_W,
  localparam int ENTRIES  = 1 << IDX_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic                 req_upg_i,
  input  logic [PORT_W-1:0]    req_port_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic                 rsp_valid_i,
  input  logic                 rsp_upg_i,
  input  logic                 rsp_data_i,
  input  logic [PORT_W-1:0]    rsp_port_i,
  input  logic [ADDR_W-1:0]    rsp_addr_i,
  output logic                 lk_valid_o,
  output logic                 lk_hit_o,
  output logic [NUM_PORTS-1:0] lk_snoop_o,
  output logic [NUM_PORTS-1:0] lk_pend_o,
  output logic                 lk_mem_o,
  output logic                 rsp_mem_o
);
  logic [ENTRIES-1:0]   vld_q;
  logic [TAG_W-1:0]     tag_q  [ENTRIES];
  logic [NUM_PORTS-1:0] hold_q [ENTRIES];
  logic [NUM_PORTS-1:0] pend_q [ENTRIES];

  logic [IDX_W-1:0] req_idx, rsp_idx;
  assign req_idx = req_addr_i[IDX_W-1:0];
  assign rsp_idx = rsp_addr_i[IDX_W-1:0];

  // response stage
  logic                 r_vld;
  logic [TAG_W-1:0]     r_tag;
  logic [NUM_PORTS-1:0] r_hold, r_pend;

  sf_rsp_update #(.NUM_PORTS(NUM_PORTS), .TAG_W(TAG_W)) u_rsp (
    .vld_i       (vld_q[rsp_idx]),
    .tag_i       (tag_q[rsp_idx]),
    .hold_i      (hold_q[rsp_idx]),
    .pend_i      (pend_q[rsp_idx]),
    .rsp_valid_i (rsp_valid_i),
    .rsp_tag_i   (rsp_addr_i[ADDR_W-1:IDX_W]),
    .rsp_port_i  (rsp_port_i),
    .rsp_upg_i   (rsp_upg_i),
    .vld_o       (r_vld),
    .tag_o       (r_tag),
    .hold_o      (r_hold),
    .pend_o      (r_pend)
  );

  // request stage sees the entry after a same-cycle response
  logic                 same;
  logic                 b_vld;
  logic [TAG_W-1:0]     b_tag;
  logic [NUM_PORTS-1:0] b_hold, b_pend;
  assign same   = rsp_valid_i && (rsp_idx == req_idx);
  assign b_vld  = same ? r_vld  : vld_q[req_idx];
  assign b_tag  = same ? r_tag  : tag_q[req_idx];
  assign b_hold = same ? r_hold : hold_q[req_idx];
  assign b_pend = same ? r_pend : pend_q[req_idx];

  logic                 q_vld, q_hit, q_mem;
  logic [TAG_W-1:0]     q_tag;
  logic [NUM_PORTS-1:0] q_hold, q_pend, q_snoop;

  sf_req_update #(.NUM_PORTS(NUM_PORTS), .TAG_W(TAG_W)) u_req (
    .vld_i      (b_vld),
    .tag_i      (b_tag),
    .hold_i     (b_hold),
    .pend_i     (b_pend),
    .req_tag_i  (req_addr_i[ADDR_W-1:IDX_W]),
    .req_port_i (req_port_i),
    .req_kind_i (req_kind_e'(req_upg_i)),
    .vld_o      (q_vld),
    .tag_o      (q_tag),
    .hold_o     (q_hold),
    .pend_o     (q_pend),
    .hit_o      (q_hit),
    .snoop_o    (q_snoop),
    .mem_o      (q_mem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        tag_q[e]  <= '0;
        hold_q[e] <= '0;
        pend_q[e] <= '0;
      end
    end else begin
      if (rsp_valid_i) begin
        vld_q[rsp_idx]  <= r_vld;
        tag_q[rsp_idx]  <= r_tag;
        hold_q[rsp_idx] <= r_hold;
        pend_q[rsp_idx] <= r_pend;
      end
      // later write wins; it already includes the response
      if (req_valid_i) begin
        vld_q[req_idx]  <= q_vld;
        tag_q[req_idx]  <= q_tag;
        hold_q[req_idx] <= q_hold;
        pend_q[req_idx] <= q_pend;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_valid_o <= 1'b0;
      lk_hit_o   <= 1'b0;
      lk_snoop_o <= '0;
      lk_pend_o  <= '0;
      lk_mem_o   <= 1'b0;
      rsp_mem_o  <= 1'b0;
    end else begin
      lk_valid_o <= req_valid_i;
      lk_hit_o   <= req_valid_i && q_hit;
      lk_snoop_o <= req_valid_i ? q_snoop : '0;
      lk_pend_o  <= req_valid_i ? q_pend : '0;
      lk_mem_o   <= req_valid_i && q_mem;
      rsp_mem_o  <= rsp_valid_i && !rsp_upg_i && !rsp_data_i;
    end
  end

  // R2
  lk_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> lk_valid_o);
  // R3
  miss_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_o && !lk_hit_o) |-> (lk_snoop_o == '0 && lk_mem_o));
  // R4
  no_self_snoop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i) |=> !lk_snoop_o[$past(req_port_i)]);
  // R3
  pend_self_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i) |=> lk_pend_o[$past(req_port_i)]);
  // R5
  upg_no_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_upg_i) |=> (!lk_mem_o || !lk_hit_o));
  // R9
  supply_no_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_i && rsp_data_i) |=> !rsp_mem_o);
endmodule

// File: tb/snoop_filter_tb_top.sv
module snoop_filter_tb_top;
  localparam int NP  = 4;
  localparam int AW  = 12;
  localparam int IW  = 2;
  localparam int ENT = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk_i = ~clk_i;

  logic          req_valid_i = 0, req_upg_i = 0, rsp_valid_i = 0, rsp_upg_i = 0, rsp_data_i = 0;
  logic [1:0]    req_port_i = 0, rsp_port_i = 0;
  logic [AW-1:0] req_addr_i = 0, rsp_addr_i = 0;
  logic          lk_valid_o, lk_hit_o, lk_mem_o, rsp_mem_o;
  logic [NP-1:0] lk_snoop_o, lk_pend_o;

  snoop_filter #(.NUM_PORTS(NP), .ADDR_W(AW), .IDX_W(IW)) dut_i (.*);

  int n_chk = 0, n_fail = 0;
  string cur_ph = "R1 reset";
  string prev_ph = "R1 reset";

  // behavioural model
  bit       m_vld [ENT];
  int       m_tag [ENT];
  bit [3:0] m_hold[ENT];
  bit [3:0] m_pend[ENT];
  bit       e_lk_valid, e_hit, e_mem, e_rsp_mem;
  bit [3:0] e_snoop, e_pend;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < ENT; e++) begin
        m_vld[e] = 0; m_tag[e] = 0; m_hold[e] = 0; m_pend[e] = 0;
      end
      e_lk_valid = 0; e_hit = 0; e_mem = 0; e_rsp_mem = 0; e_snoop = 0; e_pend = 0;
    end else begin
      e_rsp_mem = rsp_valid_i && !rsp_upg_i && !rsp_data_i;
      if (rsp_valid_i) begin
        int i; int t; bit [3:0] me;
        i = int'(rsp_addr_i) % ENT; t = int'(rsp_addr_i) / ENT;
        me = 4'b1 << rsp_port_i;
        if (m_vld[i] && m_tag[i] == t) begin
          m_pend[i] = m_pend[i] & ~me;
          if (rsp_upg_i) m_hold[i] = me;
          else m_hold[i] = m_hold[i] | me;
        end
      end
      e_lk_valid = req_valid_i;
      e_hit = 0; e_mem = 0; e_snoop = 0; e_pend = 0;
      if (req_valid_i) begin
        int i; int t; bit [3:0] me;
        i = int'(req_addr_i) % ENT; t = int'(req_addr_i) / ENT;
        me = 4'b1 << req_port_i;
        if (m_vld[i] && m_tag[i] == t) begin
          e_hit = 1;
          m_pend[i] = m_pend[i] | me;
          e_snoop = m_hold[i] & ~me;
          e_mem = !req_upg_i && (e_snoop == 0);
        end else begin
          m_vld[i] = 1; m_tag[i] = t; m_hold[i] = 0; m_pend[i] = me;
          e_mem = 1;
        end
        e_pend = m_pend[i];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s [%s]: actual=%0h expected=%0h", tag, prev_ph, act, exp);
    end
  endtask

  task automatic compare();
    chk("R2 lk_valid", 32'(lk_valid_o), 32'(e_lk_valid));
    chk("R3 lk_hit", 32'(lk_hit_o), 32'(e_hit));
    chk("R4 lk_snoop", 32'(lk_snoop_o), 32'(e_snoop));
    chk("R6 lk_pend", 32'(lk_pend_o), 32'(e_pend));
    chk("R5 lk_mem", 32'(lk_mem_o), 32'(e_mem));
    chk("R9 rsp_mem", 32'(rsp_mem_o), 32'(e_rsp_mem));
  endtask

  task automatic cyc(input bit rq, input bit up, input int p, input int a,
                     input bit sv, input bit su, input bit sd, input int sp, input int sa,
                     input string ph);
    @(negedge clk_i);
    compare();
    prev_ph = cur_ph; cur_ph = ph;
    req_valid_i = rq; req_upg_i = up; req_port_i = 2'(p); req_addr_i = AW'(a);
    rsp_valid_i = sv; rsp_upg_i = su; rsp_data_i = sd; rsp_port_i = 2'(sp); rsp_addr_i = AW'(sa);
  endtask

  task automatic idle(input string ph);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, ph);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: outputs idle during reset
    chk("R1 reset lk_valid", 32'(lk_valid_o), 0);
    chk("R1 reset rsp_mem", 32'(rsp_mem_o), 0);
    chk("R1 reset snoop", 32'(lk_snoop_o), 0);
    rst_ni = 1'b1;
    // R3 cold miss, P0 reads line 0x010
    cyc(1, 0, 0, 'h010, 0, 0, 0, 0, 0, "R3 cold miss");
    // R6/R9 memory-served response to P0
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 'h010, "R9 no supplier response");
    // R4 P1 reads: snoop P0
    cyc(1, 0, 1, 'h010, 0, 0, 0, 0, 0, "R4 read one holder");
    // R6 P0 supplies to P1
    cyc(0, 0, 0, 0, 1, 0, 1, 1, 'h010, "R6 supplied response");
    // R4 P2 reads: snoop P0 and P1
    cyc(1, 0, 2, 'h010, 0, 0, 0, 0, 0, "R4 read two holders");
    // R5 P1 upgrades: snoop P0 only
    cyc(1, 1, 1, 'h010, 0, 0, 0, 0, 0, "R5 upgrade by holder");
    // R7 upgrade completion for P1
    cyc(0, 0, 0, 0, 1, 1, 0, 1, 'h010, "R7 upgrade completion");
    // R7 check: P0 read snoops only P1
    cyc(1, 0, 0, 'h010, 0, 0, 0, 0, 0, "R7 sole holder after upgrade");
    // R8 response to untracked line, then lookup of it misses
    cyc(0, 0, 0, 0, 1, 0, 1, 3, 'h011, "R8 response miss ignored");
    cyc(1, 0, 3, 'h011, 0, 0, 0, 0, 0, "R8 lookup after stray response");
    // R8 stray response with tag mismatch on valid entry
    cyc(0, 0, 0, 0, 1, 0, 1, 2, 'h015, "R8 tag mismatch response");
    cyc(1, 0, 2, 'h011, 0, 0, 0, 0, 0, "R8 entry untouched");
    // R10 same-cycle response then request on one entry
    cyc(1, 0, 1, 'h011, 1, 0, 1, 3, 'h011, "R10 same cycle order");
    // R3 conflicting tag replaces entry, then original misses
    cyc(1, 0, 0, 'h014, 0, 0, 0, 0, 0, "R3 alias replace");
    cyc(1, 0, 0, 'h010, 0, 0, 0, 0, 0, "R3 evicted line misses");
    idle("R2 idle");
    // random mix across aliasing lines
    for (int k = 0; k < 600; k++) begin
      int addrs[6];
      addrs = '{'h010, 'h014, 'h011, 'h022, 'h015, 'h0A0};
      cyc($urandom_range(1, 0) == 1, $urandom_range(3, 0) == 0, $urandom_range(3, 0),
          addrs[$urandom_range(5, 0)],
          $urandom_range(1, 0) == 1, $urandom_range(3, 0) == 0, $urandom_range(1, 0) == 1,
          $urandom_range(3, 0), addrs[$urandom_range(5, 0)], "R10 random mix");
    end
    idle("R2 drain");
    @(negedge clk_i);
    compare();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule